// File: doc/BRIEF.md
# Bus Crosstalk Transition Classifier

This block watches a registered n-bit on-chip bus and sorts every word-to-word transition by the capacitive coupling it causes. Each accepted word is compared with the previous accepted word. Every inner wire is treated as the centre of a group of three adjacent wires: itself and its two direct neighbours. The block decides which coupling class, if any, the centre wire sees. Wires further away are ignored.

Running totals are kept for rising self transitions and for the four coupling classes. A weighted net switching activity is also accumulated in fixed point. Class k carries weight k, and a coupling-to-ground ratio scales the weighted sum. Designers use the counters to compare bus encodings or data sets on a live bus, without a capacitance extractor.

A one-cycle synchronous clear zeroes all totals. It leaves the last accepted word in place as the reference for the next comparison.

Top module: `xtalk_classifier`

## Requirements
- R1: After reset every counter output (`self_cnt`, `type1_cnt`, `type2_cnt`, `type3_cnt`, `type4_cnt`) and `net_act` read zero.
- R2: The first word with `valid` high after reset only becomes the reference word. It changes no counter.
- R3: A cycle with `valid` low has no effect. The counters hold, and the next valid word is compared against the last word that was accepted with `valid` high.
- R4: `self_cnt` grows by the number of bus wires that go from 0 to 1 between the reference word and the new word.
- R5: A group counts as type-1 when exactly one of its three wires changes. The changing wire may be the centre or either neighbour.
- R6: A group counts as type-2 when the centre toggles, one neighbour moves the opposite way, and the other neighbour moves the same way as the centre.
- R7: A group counts as type-3 when the centre toggles, one neighbour moves the opposite way, and the other neighbour is quiet.
- R8: A group counts as type-4 when all three wires toggle and the centre moves opposite to both neighbours. Alternating 0x55 and 0xAA on an 8-bit bus gives six type-4 groups per word.
- R9: A group lands in at most one class. Groups in no class (for example all three moving the same way, or two wires changing together in the same direction) add nothing.
- R10: Wires 1 to WIDTH-2 are each the centre of one group. Wires 0 and WIDTH-1 act only as neighbours. Toggling wire 0 alone gives one type-1 group, and toggling wire 3 alone gives three.
- R11: `net_act` is unsigned fixed point with FRAC_W fraction bits (default 8). Per word it grows by self·2^FRAC_W + ALPHA_Q·(4·N4 + 3·N3 + 2·N2 + N1), where ALPHA_Q defaults to 819 (about 3.2).
- R12: Every counter and `net_act` saturate at their all-ones value instead of wrapping.
- R13: `clr` high zeroes all counters at the next edge and takes priority over counting. The word presented with it still becomes the reference.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| valid | input | 1 | Bus word strobe |
| bus_in | input | WIDTH | Observed bus word |
| self_cnt | output | CNT_W | Rising self transitions |
| type1_cnt | output | CNT_W | Type-1 groups |
| type2_cnt | output | CNT_W | Type-2 groups |
| type3_cnt | output | CNT_W | Type-3 groups |
| type4_cnt | output | CNT_W | Type-4 groups |
| net_act | output | NET_W | Weighted net activity, FRAC_W fraction bits |

## Verification
The reference word is the only hidden state, and a wrong one shows up on the very next valid word. One way this happens is a reference that was updated while `valid` was low. Another is a first word that was classified. Either way, a counter steps by an amount the transition does not justify, and the error is seen one edge after that word.

A wrong class decision appears in the same cycle as a mismatch in one type counter and in `net_act`. A broken saturation or clear path appears as a wrap or a non-zero count on the edge after the event. The bench compares all six outputs after every scenario, and after every word of a long pseudo-random stream, against a class model derived from the requirements.

// File: rtl/xtalk_classifier.sv
module xtalk_classifier #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NET_W   = 24,
  parameter int unsigned FRAC_W  = 8,
  parameter int unsigned ALPHA_Q = 819
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             valid,
  input  logic [WIDTH-1:0] bus_in,
  output logic [CNT_W-1:0] self_cnt,
  output logic [CNT_W-1:0] type1_cnt,
  output logic [CNT_W-1:0] type2_cnt,
  output logic [CNT_W-1:0] type3_cnt,
  output logic [CNT_W-1:0] type4_cnt,
  output logic [NET_W-1:0] net_act
);
  localparam int unsigned PC_W = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] prev;
  logic             primed;
  logic [WIDTH-1:0] rise, fall, chg;
  logic [WIDTH-2:1] k1, k2, k3, k4;
  logic [PC_W-1:0]  n_self, n1, n2, n3, n4;
  logic [NET_W-1:0] wsum, net_inc;
  logic             count_en;

  assign rise = bus_in & ~prev;
  assign fall = ~bus_in & prev;
  assign chg  = rise | fall;

  for (genvar i = 1; i <= WIDTH - 2; i++) begin : g_grp
    logic opp_l, opp_r, same_l, same_r;
    assign opp_l  = (rise[i] & fall[i-1]) | (fall[i] & rise[i-1]);
    assign opp_r  = (rise[i] & fall[i+1]) | (fall[i] & rise[i+1]);
    assign same_l = (rise[i] & rise[i-1]) | (fall[i] & fall[i-1]);
    assign same_r = (rise[i] & rise[i+1]) | (fall[i] & fall[i+1]);
    assign k1[i]  = $onehot({chg[i-1], chg[i], chg[i+1]});
    assign k2[i]  = (opp_l & same_r) | (opp_r & same_l);
    assign k3[i]  = (opp_l & ~chg[i+1]) | (opp_r & ~chg[i-1]);
    assign k4[i]  = opp_l & opp_r;
  end

  assign n_self = PC_W'($countones(rise));
  assign n1     = PC_W'($countones(k1));
  assign n2     = PC_W'($countones(k2));
  assign n3     = PC_W'($countones(k3));
  assign n4     = PC_W'($countones(k4));

  assign wsum    = NET_W'(n1) + (NET_W'(n2) << 1) + (NET_W'(n3) << 1) + NET_W'(n3)
                 + (NET_W'(n4) << 2);
  assign net_inc = (NET_W'(n_self) << FRAC_W) + NET_W'(ALPHA_Q) * wsum;

  assign count_en = valid & primed & ~clr;

  function automatic logic [CNT_W-1:0] sat_cnt(input logic [CNT_W-1:0] a,
                                               input logic [PC_W-1:0]  b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {{(CNT_W + 1 - PC_W){1'b0}}, b};
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  function automatic logic [NET_W-1:0] sat_net(input logic [NET_W-1:0] a,
                                               input logic [NET_W-1:0] b);
    logic [NET_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[NET_W] ? {NET_W{1'b1}} : s[NET_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= '0;
      primed <= 1'b0;
    end else if (valid) begin
      prev   <= bus_in;
      primed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      self_cnt  <= '0;
      type1_cnt <= '0;
      type2_cnt <= '0;
      type3_cnt <= '0;
      type4_cnt <= '0;
      net_act   <= '0;
    end else if (clr) begin
      self_cnt  <= '0;
      type1_cnt <= '0;
      type2_cnt <= '0;
      type3_cnt <= '0;
      type4_cnt <= '0;
      net_act   <= '0;
    end else if (count_en) begin
      self_cnt  <= sat_cnt(self_cnt, n_self);
      type1_cnt <= sat_cnt(type1_cnt, n1);
      type2_cnt <= sat_cnt(type2_cnt, n2);
      type3_cnt <= sat_cnt(type3_cnt, n3);
      type4_cnt <= sat_cnt(type4_cnt, n4);
      net_act   <= sat_net(net_act, net_inc);
    end
  end
endmodule

module xtalk_classifier_chk #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned NET_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             valid,
  input logic             primed,
  input logic [CNT_W-1:0] self_cnt,
  input logic [CNT_W-1:0] type1_cnt,
  input logic [CNT_W-1:0] type2_cnt,
  input logic [CNT_W-1:0] type3_cnt,
  input logic [CNT_W-1:0] type4_cnt,
  input logic [NET_W-1:0] net_act
);
  logic [5*CNT_W+NET_W-1:0] all_cnt;
  assign all_cnt = {self_cnt, type1_cnt, type2_cnt, type3_cnt, type4_cnt, net_act};

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (all_cnt == '0)); // R13

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !clr) |=> $stable(all_cnt)); // R3

  AST_FIRST_WORD_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !primed && !clr) |=> $stable(all_cnt)); // R2

  AST_NET_NEVER_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (net_act >= $past(net_act))); // R12

  AST_SELF_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((self_cnt - $past(self_cnt)) <= CNT_W'(WIDTH))); // R4

  AST_TYPE4_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((type4_cnt - $past(type4_cnt)) <= CNT_W'(WIDTH - 2))); // R10
endmodule

bind xtalk_classifier xtalk_classifier_chk #(
  .WIDTH(WIDTH), .CNT_W(CNT_W), .NET_W(NET_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .valid(valid), .primed(primed),
  .self_cnt(self_cnt), .type1_cnt(type1_cnt), .type2_cnt(type2_cnt),
  .type3_cnt(type3_cnt), .type4_cnt(type4_cnt), .net_act(net_act)
);

// File: tb/tb_xtalk_classifier.sv
module tb_xtalk_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int W      = 8;
  localparam int CW     = 16;
  localparam int NW     = 24;
  localparam int FRAC   = 8;
  localparam int ALPHA  = 819;
  localparam longint CMAX = (64'd1 << CW) - 1;
  localparam longint NMAX = (64'd1 << NW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          valid = 1'b0;
  logic [W-1:0]  bus_in = '0;
  logic [CW-1:0] self_cnt, type1_cnt, type2_cnt, type3_cnt, type4_cnt;
  logic [NW-1:0] net_act;

  int checks = 0;
  int errors = 0;

  longint m_self, m_t1, m_t2, m_t3, m_t4, m_net;
  logic [W-1:0] m_prev;
  bit m_primed;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xtalk_classifier dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .valid(valid), .bus_in(bus_in),
    .self_cnt(self_cnt), .type1_cnt(type1_cnt), .type2_cnt(type2_cnt),
    .type3_cnt(type3_cnt), .type4_cnt(type4_cnt), .net_act(net_act)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "self",  longint'(self_cnt),  m_self);
    check(req, "type1", longint'(type1_cnt), m_t1);
    check(req, "type2", longint'(type2_cnt), m_t2);
    check(req, "type3", longint'(type3_cnt), m_t3);
    check(req, "type4", longint'(type4_cnt), m_t4);
    check(req, "net",   longint'(net_act),   m_net);
  endtask

  function automatic longint sat(input longint v, input longint mx);
    return (v > mx) ? mx : v;
  endfunction

  task automatic model_word(input logic [W-1:0] nw);
    int s, c1, c2, c3, c4;
    s = 0; c1 = 0; c2 = 0; c3 = 0; c4 = 0;
    for (int b = 0; b < W; b++)
      if (!m_prev[b] && nw[b]) s++;
    for (int c = 1; c < W - 1; c++) begin
      int dl, dc, dr, nz;
      dl = int'(nw[c-1]) - int'(m_prev[c-1]);
      dc = int'(nw[c])   - int'(m_prev[c]);
      dr = int'(nw[c+1]) - int'(m_prev[c+1]);
      nz = (dl != 0 ? 1 : 0) + (dc != 0 ? 1 : 0) + (dr != 0 ? 1 : 0);
      if (nz == 1) c1++;
      else if (dc != 0) begin
        if (dl == -dc && dr == -dc) c4++;
        else if ((dl == -dc && dr == 0) || (dr == -dc && dl == 0)) c3++;
        else if ((dl == -dc && dr == dc) || (dr == -dc && dl == dc)) c2++;
      end
    end
    m_self = sat(m_self + s, CMAX);
    m_t1 = sat(m_t1 + c1, CMAX);
    m_t2 = sat(m_t2 + c2, CMAX);
    m_t3 = sat(m_t3 + c3, CMAX);
    m_t4 = sat(m_t4 + c4, CMAX);
    m_net = sat(m_net + (longint'(s) << FRAC)
                + longint'(ALPHA) * (4 * c4 + 3 * c3 + 2 * c2 + c1), NMAX);
  endtask

  task automatic model_zero();
    m_self = 0; m_t1 = 0; m_t2 = 0; m_t3 = 0; m_t4 = 0; m_net = 0;
  endtask

  task automatic step(input bit v, input bit c, input logic [W-1:0] w);
    valid = v; clr = c; bus_in = w;
    @(posedge clk);
    if (c) model_zero();
    else if (v && m_primed) model_word(w);
    if (v) begin m_prev = w; m_primed = 1'b1; end
    @(negedge clk);
    valid = 1'b0; clr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; valid = 1'b0; clr = 1'b0;
    model_zero(); m_prev = '0; m_primed = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check_all("R1");
  endtask

  task automatic t_first_word();
    do_reset();
    step(1, 0, 8'hA5);
    check_all("R2");
    check("R2", "self after first word", longint'(self_cnt), 0);
  endtask

  task automatic t_idle_ignored();
    do_reset();
    step(1, 0, 8'h00);
    step(0, 0, 8'hFF);
    step(0, 0, 8'h5A);
    check("R3", "self while idle", longint'(self_cnt), 0);
    check("R3", "net while idle", longint'(net_act), 0);
    step(1, 0, 8'h01);
    check("R3", "type1 vs last accepted", longint'(type1_cnt), 1);
    check_all("R3");
  endtask

  task automatic t_edge_wire();
    do_reset();
    step(1, 0, 8'h00);
    step(1, 0, 8'h01);
    check("R10", "wire0 type1", longint'(type1_cnt), 1);
    check("R11", "wire0 net", longint'(net_act), 256 + 819);
    step(1, 0, 8'h00);
    step(1, 0, 8'h08);
    check("R10", "wire3 type1", longint'(type1_cnt), 1 + 1 + 3);
    check("R4", "self rises", longint'(self_cnt), 2);
    check_all("R10");
  endtask

  task automatic t_type_patterns();
    do_reset();
    step(1, 0, 8'h05);
    step(1, 0, 8'h02);
    check("R8", "101 to 010 type4", longint'(type4_cnt), 1);
    check("R7", "neighbour group type3", longint'(type3_cnt), 1);
    check_all("R8");
    step(1, 0, 8'h01);
    step(1, 0, 8'h06);
    check_all("R6");
    step(1, 0, 8'h05);
    step(1, 0, 8'h06);
    check_all("R7");
    step(1, 0, 8'h06);
    step(1, 0, 8'h07);
    check_all("R5");
    check("R11", "net after patterns", longint'(net_act), m_net);
  endtask

  task automatic t_no_class();
    do_reset();
    step(1, 0, 8'h00);
    step(1, 0, 8'hFF);
    check("R9", "all rise type1", longint'(type1_cnt), 0);
    check("R9", "all rise type2", longint'(type2_cnt), 0);
    check("R9", "all rise type4", longint'(type4_cnt), 0);
    check("R4", "all rise self", longint'(self_cnt), 8);
    check("R11", "all rise net", longint'(net_act), 8 * 256);
  endtask

  task automatic t_random();
    logic [W-1:0] w;
    do_reset();
    w = 8'h3C;
    for (int n = 0; n < 400; n++) begin
      w = {w[6:0], w[7] ^ w[5] ^ w[4] ^ w[3]} ^ W'(n);
      step((n % 7) != 3, 0, w);
      check_all("R9");
    end
  endtask

  task automatic t_saturate_and_clear();
    do_reset();
    step(1, 0, 8'h55);
    step(1, 0, 8'hAA);
    check("R8", "alternating type4", longint'(type4_cnt), 6);
    for (int n = 0; n < 11000; n++)
      step(1, 0, (n % 2 == 0) ? 8'h55 : 8'hAA);
    check("R12", "type4 saturated", longint'(type4_cnt), CMAX);
    check("R12", "net saturated", longint'(net_act), NMAX);
    check_all("R12");
    step(1, 1, 8'h00);
    check_all("R13");
    check("R13", "net cleared", longint'(net_act), 0);
    step(1, 0, 8'h01);
    check("R13", "reference kept", longint'(self_cnt), 1);
    check_all("R13");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_first_word();
    t_idle_ignored();
    t_edge_wire();
    t_type_patterns();
    t_no_class();
    t_random();
    t_saturate_and_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule